// File: doc/BRIEF.md
# Transmit Channel Status and Event Register

This block is the status and event register for one transmit channel. It turns single-cycle error event pulses into sticky flags that software clears by writing ones. It keeps a wrapping count of transmitted packets and a copy of that count for the latest packet carrying a mark. It raises two level interrupts: a notification interrupt for marked packets and an error interrupt for the error flags. Each interrupt source can be masked, and every mask bit comes out of reset set. A debug-injection address lets software set any flag directly.

Marked-packet notification has two modes. In the direct mode, a marked packet sets the marked flag at once. If the marked flag is already set, the overflow-marked flag is set too. In the mailbox mode, software arms a mailbox-enable bit. The next marked packet then raises a mailbox request that carries a snapshot of the status word. The marked and overflow-marked updates are held back until the external mailbox writer reports completion. At that point hardware also clears mailbox-enable. The mailbox DMA itself sits outside this block.

Top module: `txq_event_csr`

## Requirements
- R1: Coming out of reset, the status word (address 0) reads all zero and the mask word (address 1) reads 0x7FF. Both interrupts and `mbox_req` are low.
- R2: A pulse on `err_evt[k]` sets status bit k (k = 0..9). Writing 1 to bit k at address 0 clears that bit. Writing 0 to bit k leaves it unchanged.
- R3: When a hardware set and a software clear reach the same flag in the same cycle, the flag ends up set. This holds for the error flags, marked (bit 10) and overflow-marked (bit 11).
- R4: `irq_err` is high when some error flag k is set and mask bit k is 0. `irq_note` is high when marked is set and mask bit 10 is 0. Mask bits are written at address 1.
- R5: Each cycle with `tx_done` high adds one to the 12-bit packet count in status bits [43:32]. The count wraps from 4095 to 0.
- R6: A packet with `tx_mark` high loads status bits [27:16] with the packet count that includes that packet.
- R7: In direct mode (mailbox-enable, bit 12, clear), a marked packet sets marked. If marked was already set, it also sets overflow-marked.
- R8: Writing 1 to bit 10 at address 0 clears overflow-marked. It clears marked only when overflow-marked was 0 before the write.
- R9: Writing 1 to bit 12 at address 0 arms mailbox mode. The next marked packet raises `mbox_req`, which stays high until `mbox_done`, and marked and overflow-marked do not change meanwhile. On `mbox_done`, `mbox_req` and mailbox-enable clear. Marked then sets, and overflow-marked sets if marked was already set or another marked packet arrived while the request was pending.
- R10: `mbox_data` holds the status word taken when the request is raised. Its counts already include the triggering packet. Its marked and overflow-marked bits are the values from before that packet, and its mailbox-enable bit is 1.
- R11: Writing ones to address 2 sets the matching error, marked and overflow-marked bits. A read at address 2 returns the status word.
- R12: `fatal_pulse` is high for exactly one cycle, the cycle in which an error flag first reads 1 after being 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 mask, 2 inject |
| reg_wdata | input | 13 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` |
| err_evt | input | 10 | Error event pulses |
| tx_done | input | 1 | Packet transmitted strobe |
| tx_mark | input | 1 | Transmitted packet carries a mark |
| mbox_req | output | 1 | Mailbox write request |
| mbox_data | output | 64 | Status snapshot for the mailbox |
| mbox_done | input | 1 | Mailbox write completed |
| irq_note | output | 1 | Notification interrupt |
| irq_err | output | 1 | Error interrupt |
| fatal_pulse | output | 1 | One-cycle pulse on a new error flag |

## Verification
The hardest situation to reach is a second marked packet arriving while a mailbox request is still outstanding. That packet must leave the visible flags untouched, yet still add overflow-marked when the request completes. The stimulus arms mailbox-enable, sends a marked packet, and holds off `mbox_done` for several cycles. During that wait it sends another marked packet, and it checks the flags both before and after the completion. A write-one to marked is also issued in the same cycle as a marked packet, which exercises the set-over-clear priority on both marked flags.

// File: rtl/txq_evt_pkg.sv
package txq_evt_pkg;
  localparam int ERR_N_DEF = 10;
  localparam int CNT_W_DEF = 12;
  localparam int RD_W      = 64;
  localparam int LMK_LSB   = 16;
  localparam int CNT_LSB   = 32;
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_INJ  = 2'd2;
endpackage

// File: rtl/txq_err_flags.sv
module txq_err_flags #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] inj_set,
  input  logic [N-1:0] sw_clr,
  output logic [N-1:0] flags,
  output logic         fatal
);
  logic [N-1:0] flag_nxt;
  logic         fatal_nxt;
  logic         upd;

  always_comb begin
    flag_nxt  = (flags & ~sw_clr) | hw_set | inj_set;
    fatal_nxt = |(flag_nxt & ~flags);
    upd       = |(hw_set | inj_set | sw_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (upd) begin
      flags <= flag_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fatal <= 1'b0;
    else        fatal <= fatal_nxt;
  end
endmodule

// File: rtl/txq_mark_trk.sv
module txq_mark_trk #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_done,
  input  logic             tx_mark,
  input  logic             sw_mark_w1,
  input  logic             inj_mark,
  input  logic             inj_ovf,
  input  logic             sw_mb_set,
  input  logic             mbox_done,
  output logic [CNT_W-1:0] pkt_cnt,
  output logic [CNT_W-1:0] last_mark,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] lmk_nxt,
  output logic             marked,
  output logic             ovf,
  output logic             mb_en,
  output logic             req,
  output logic             take
);
  logic mark_tx, direct, queued, done;
  logic hw_mark_set, hw_ovf_set;
  logic marked_nxt, ovf_nxt, mb_nxt, req_nxt, extra_nxt;
  logic extra;

  always_comb begin
    mark_tx     = tx_done & tx_mark;
    cnt_nxt     = tx_done ? pkt_cnt + 1'b1 : pkt_cnt;
    lmk_nxt     = mark_tx ? pkt_cnt + 1'b1 : last_mark;
    direct      = mark_tx & ~mb_en;
    take        = mark_tx & mb_en & ~req;
    queued      = mark_tx & req;
    done        = req & mbox_done;
    hw_mark_set = direct | done;
    hw_ovf_set  = (direct & marked) | (done & (marked | extra | queued));

    if (hw_mark_set || inj_mark)     marked_nxt = 1'b1;
    else if (sw_mark_w1 && !ovf)     marked_nxt = 1'b0;
    else                             marked_nxt = marked;

    if (hw_ovf_set || inj_ovf)       ovf_nxt = 1'b1;
    else if (sw_mark_w1)             ovf_nxt = 1'b0;
    else                             ovf_nxt = ovf;

    if (done)           mb_nxt = 1'b0;
    else if (sw_mb_set) mb_nxt = 1'b1;
    else                mb_nxt = mb_en;

    if (take)      req_nxt = 1'b1;
    else if (done) req_nxt = 1'b0;
    else           req_nxt = req;

    if (done)        extra_nxt = 1'b0;
    else if (queued) extra_nxt = 1'b1;
    else             extra_nxt = extra;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_cnt   <= '0;
      last_mark <= '0;
    end else if (tx_done) begin
      pkt_cnt   <= cnt_nxt;
      last_mark <= lmk_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      marked <= 1'b0;
      ovf    <= 1'b0;
      mb_en  <= 1'b0;
      req    <= 1'b0;
      extra  <= 1'b0;
    end else begin
      marked <= marked_nxt;
      ovf    <= ovf_nxt;
      mb_en  <= mb_nxt;
      req    <= req_nxt;
      extra  <= extra_nxt;
    end
  end
endmodule

// File: rtl/txq_irq_gen.sv
module txq_irq_gen #(
  parameter int N = 10
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] err_mask,
  input  logic         marked,
  input  logic         mark_mask,
  output logic         irq_err,
  output logic         irq_note
);
  logic [N-1:0] live;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign live[i] = flags[i] & ~err_mask[i];
  end

  assign irq_err  = |live;
  assign irq_note = marked & ~mark_mask;
endmodule

// File: rtl/txq_event_csr.sv
module txq_event_csr
  import txq_evt_pkg::*;
#(
  parameter int N_ERR = ERR_N_DEF,
  parameter int CNT_W = CNT_W_DEF,
  localparam int MARK_B = N_ERR,
  localparam int OVF_B  = N_ERR + 1,
  localparam int MBEN_B = N_ERR + 2,
  localparam int WR_W   = N_ERR + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [WR_W-1:0]  reg_wdata,
  output logic [RD_W-1:0]  reg_rdata,
  input  logic [N_ERR-1:0] err_evt,
  input  logic             tx_done,
  input  logic             tx_mark,
  output logic             mbox_req,
  output logic [RD_W-1:0]  mbox_data,
  input  logic             mbox_done,
  output logic             irq_note,
  output logic             irq_err,
  output logic             fatal_pulse
);
  logic wr_stat, wr_mask, wr_inj;
  logic [N_ERR-1:0] err_clr, err_inj, err_flags;
  logic [N_ERR-1:0] err_mask_q, err_mask_nxt;
  logic mark_mask_q, mark_mask_nxt;
  logic [CNT_W-1:0] pkt_cnt, last_mark, cnt_nxt, lmk_nxt;
  logic marked_q, ovf_q, mb_en, take;
  logic [RD_W-1:0] stat_word, snap_word, mask_word, snap_q;

  always_comb begin
    wr_stat = reg_we && (reg_addr == A_STAT);
    wr_mask = reg_we && (reg_addr == A_MASK);
    wr_inj  = reg_we && (reg_addr == A_INJ);
    err_clr = wr_stat ? reg_wdata[N_ERR-1:0] : '0;
    err_inj = wr_inj  ? reg_wdata[N_ERR-1:0] : '0;
  end

  txq_err_flags #(.N(N_ERR)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_set  (err_evt),
    .inj_set (err_inj),
    .sw_clr  (err_clr),
    .flags   (err_flags),
    .fatal   (fatal_pulse)
  );

  txq_mark_trk #(.CNT_W(CNT_W)) u_mark (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_done    (tx_done),
    .tx_mark    (tx_mark),
    .sw_mark_w1 (wr_stat & reg_wdata[MARK_B]),
    .inj_mark   (wr_inj & reg_wdata[MARK_B]),
    .inj_ovf    (wr_inj & reg_wdata[OVF_B]),
    .sw_mb_set  (wr_stat & reg_wdata[MBEN_B]),
    .mbox_done  (mbox_done),
    .pkt_cnt    (pkt_cnt),
    .last_mark  (last_mark),
    .cnt_nxt    (cnt_nxt),
    .lmk_nxt    (lmk_nxt),
    .marked     (marked_q),
    .ovf        (ovf_q),
    .mb_en      (mb_en),
    .req        (mbox_req),
    .take       (take)
  );

  txq_irq_gen #(.N(N_ERR)) u_irq (
    .flags     (err_flags),
    .err_mask  (err_mask_q),
    .marked    (marked_q),
    .mark_mask (mark_mask_q),
    .irq_err   (irq_err),
    .irq_note  (irq_note)
  );

  // mask register
  always_comb begin
    err_mask_nxt  = reg_wdata[N_ERR-1:0];
    mark_mask_nxt = reg_wdata[MARK_B];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_mask_q  <= '1;
      mark_mask_q <= 1'b1;
    end else if (wr_mask) begin
      err_mask_q  <= err_mask_nxt;
      mark_mask_q <= mark_mask_nxt;
    end
  end

  // word assembly
  always_comb begin
    stat_word                       = '0;
    stat_word[N_ERR-1:0]            = err_flags;
    stat_word[MARK_B]               = marked_q;
    stat_word[OVF_B]                = ovf_q;
    stat_word[MBEN_B]               = mb_en;
    stat_word[LMK_LSB +: CNT_W]     = last_mark;
    stat_word[CNT_LSB +: CNT_W]     = pkt_cnt;

    snap_word                       = stat_word;
    snap_word[MBEN_B]               = 1'b1;
    snap_word[LMK_LSB +: CNT_W]     = lmk_nxt;
    snap_word[CNT_LSB +: CNT_W]     = cnt_nxt;

    mask_word                       = '0;
    mask_word[N_ERR-1:0]            = err_mask_q;
    mask_word[MARK_B]               = mark_mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap_q <= '0;
    else if (take) snap_q <= snap_word;
  end

  assign mbox_data = snap_q;

  always_comb begin
    case (reg_addr)
      A_STAT, A_INJ: reg_rdata = stat_word;
      A_MASK:        reg_rdata = mask_word;
      default:       reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/txq_event_csr_chk.sv
module txq_event_csr_chk
  import txq_evt_pkg::*;
#(
  parameter int N     = 10,
  parameter int CNT_W = 12,
  parameter int WR_W  = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [WR_W-1:0]  reg_wdata,
  input logic [N-1:0]     err_evt,
  input logic [N-1:0]     err_q,
  input logic             tx_done,
  input logic [CNT_W-1:0] pkt_cnt,
  input logic             mbox_req,
  input logic             mbox_done,
  input logic             mb_en,
  input logic             marked,
  input logic             fatal_pulse
);
  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_STAT && err_evt == '0)
      |=> ((err_q & $past(reg_wdata[N-1:0])) == '0));

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt) |=> ((err_q & $past(err_evt)) == $past(err_evt)));

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (pkt_cnt == CNT_W'($past(pkt_cnt) + 1'b1)));

  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_done |=> $stable(pkt_cnt));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_req && !mbox_done) |=> mbox_req);

  p_done_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_req && mbox_done) |=> (!mbox_req && !mb_en));

  p_defer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_req && !mbox_done && !(reg_we && reg_addr == A_INJ)) |=> !$rose(marked));

  p_fatal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_pulse |-> ((err_q & ~$past(err_q)) != '0));
endmodule

bind txq_event_csr txq_event_csr_chk #(.N(N_ERR), .CNT_W(CNT_W), .WR_W(WR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .err_evt     (err_evt),
  .err_q       (err_flags),
  .tx_done     (tx_done),
  .pkt_cnt     (pkt_cnt),
  .mbox_req    (mbox_req),
  .mbox_done   (mbox_done),
  .mb_en       (mb_en),
  .marked      (marked_q),
  .fatal_pulse (fatal_pulse)
);

// File: tb/txq_event_csr_test.sv
`timescale 1ns/1ps
module txq_event_csr_test;
  localparam int M = 10, O = 11, B = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [12:0] reg_wdata = '0;
  logic [63:0] reg_rdata, mbox_data;
  logic [9:0]  err_evt = '0;
  logic        tx_done = 1'b0, tx_mark = 1'b0, mbox_done = 1'b0;
  logic        mbox_req, irq_note, irq_err, fatal_pulse;

  int n_chk = 0, n_bad = 0;
  int cnt = 0, lmk = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  txq_event_csr uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_evt(err_evt),
    .tx_done(tx_done), .tx_mark(tx_mark), .mbox_req(mbox_req),
    .mbox_data(mbox_data), .mbox_done(mbox_done), .irq_note(irq_note),
    .irq_err(irq_err), .fatal_pulse(fatal_pulse)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] stw(input logic [9:0] e, input bit m, input bit o,
                                      input bit b, input int l, input int c);
    logic [63:0] w = '0;
    w[9:0] = e; w[M] = m; w[O] = o; w[B] = b;
    w[27:16] = l[11:0]; w[43:32] = c[11:0];
    return w;
  endfunction

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [12:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick;
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic tx(input bit mk);
    tx_done = 1'b1; tx_mark = mk;
    tick;
    tx_done = 1'b0; tx_mark = 1'b0;
    cnt = (cnt + 1) % 4096;
    if (mk) lmk = cnt;
  endtask

  task automatic clr_mark;
    wr(2'd0, 13'(1 << M));
    wr(2'd0, 13'(1 << M));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 status", d, 64'h0);
    rd(2'd1, d); chk("R1 mask", d, 64'h7FF);
    chk("R1 irqs", {irq_note, irq_err, mbox_req}, 3'b000);

    // R2 R3 R4 R12 per error bit
    for (int k = 0; k < 10; k++) begin
      err_evt = 10'(1 << k); tick; err_evt = '0;
      chk("R12 fatal high", fatal_pulse, 1'b1);
      rd(2'd0, d); chk("R2 set", d, stw(10'(1 << k), 0, 0, 0, 0, 0));
      chk("R4 masked err", irq_err, 1'b0);
      tick; chk("R12 fatal one cycle", fatal_pulse, 1'b0);
      wr(2'd1, 13'h7FF & ~13'(1 << k));
      chk("R4 unmasked err", irq_err, 1'b1);
      wr(2'd1, 13'h7FF);
      chk("R4 remasked err", irq_err, 1'b0);
      wr(2'd0, 13'h3FF & ~13'(1 << k));
      rd(2'd0, d); chk("R2 write zero kept", d, stw(10'(1 << k), 0, 0, 0, 0, 0));
      wr(2'd0, 13'(1 << k));
      rd(2'd0, d); chk("R2 w1c", d, 64'h0);
      // R3 set beats clear
      err_evt = 10'(1 << k); reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 13'(1 << k);
      tick;
      err_evt = '0; reg_we = 1'b0; reg_wdata = '0;
      rd(2'd0, d); chk("R3 err set wins", d, stw(10'(1 << k), 0, 0, 0, 0, 0));
      wr(2'd0, 13'(1 << k));
    end

    // R5 counter wrap
    tx_done = 1'b1;
    repeat (4095) tick;
    tx_done = 1'b0; cnt = 4095;
    rd(2'd0, d); chk("R5 count 4095", d, stw(0, 0, 0, 0, 0, 4095));
    tx(0);
    rd(2'd0, d); chk("R5 wrap to 0", d, stw(0, 0, 0, 0, 0, 0));
    for (int i = 0; i < 4; i++) tx(0);
    rd(2'd0, d); chk("R5 count 4", d, stw(0, 0, 0, 0, 0, 4));

    // R6 R7 direct mode
    tx(1);
    rd(2'd0, d); chk("R6 R7 first mark", d, stw(0, 1, 0, 0, lmk, cnt));
    chk("R4 note masked", irq_note, 1'b0);
    wr(2'd1, 13'h3FF);
    chk("R4 note unmasked", irq_note, 1'b1);
    tx(0); tx(1);
    rd(2'd0, d); chk("R7 overflow mark", d, stw(0, 1, 1, 0, lmk, cnt));
    chk("R6 last mark value", d[27:16], 64'(lmk));
    wr(2'd0, 13'(1 << M));
    rd(2'd0, d); chk("R8 marked kept", d, stw(0, 1, 0, 0, lmk, cnt));
    wr(2'd0, 13'(1 << M));
    rd(2'd0, d); chk("R8 marked cleared", d, stw(0, 0, 0, 0, lmk, cnt));
    chk("R4 note low", irq_note, 1'b0);

    // R8 R11 sweep over flag states via injection
    for (int s = 0; s < 4; s++) begin
      bit m = s[0], o = s[1];
      clr_mark;
      wr(2'd2, 13'({o, m} << M));
      rd(2'd2, d); chk("R11 inject", d, stw(0, m, o, 0, lmk, cnt));
      wr(2'd0, 13'(1 << M));
      rd(2'd0, d); chk("R8 w1 marked", d, stw(0, m & o, 0, 0, lmk, cnt));
    end

    // R3 on marked flags
    clr_mark;
    tx(1);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 13'(1 << M);
    tx(1);
    reg_we = 1'b0; reg_wdata = '0;
    rd(2'd0, d); chk("R3 mark set wins", d, stw(0, 1, 1, 0, lmk, cnt));

    // R9 R10 mailbox with queued second mark
    clr_mark;
    wr(2'd2, 13'(1 << 5));
    wr(2'd0, 13'(1 << B));
    rd(2'd0, d); chk("R9 armed", d, stw(10'h20, 0, 0, 1, lmk, cnt));
    tx(0);
    chk("R9 no req unmarked", mbox_req, 1'b0);
    tx(1);
    chk("R9 req raised", mbox_req, 1'b1);
    chk("R10 snapshot", mbox_data, stw(10'h20, 0, 0, 1, lmk, cnt));
    rd(2'd0, d); chk("R9 deferred", d, stw(10'h20, 0, 0, 1, lmk, cnt));
    repeat (3) tick;
    chk("R9 req held", mbox_req, 1'b1);
    tx(1);
    rd(2'd0, d); chk("R9 queued deferred", d, stw(10'h20, 0, 0, 1, lmk, cnt));
    mbox_done = 1'b1; tick; mbox_done = 1'b0;
    chk("R9 req dropped", mbox_req, 1'b0);
    rd(2'd0, d); chk("R9 done queued", d, stw(10'h20, 1, 1, 0, lmk, cnt));
    wr(2'd0, 13'(1 << 5));

    // mailbox with marked already set
    clr_mark;
    tx(1);
    wr(2'd0, 13'(1 << B));
    tx(1);
    chk("R10 snapshot premarked", mbox_data, stw(0, 1, 0, 1, lmk, cnt));
    rd(2'd0, d); chk("R9 premarked deferred", d, stw(0, 1, 0, 1, lmk, cnt));
    mbox_done = 1'b1; tick; mbox_done = 1'b0;
    rd(2'd0, d); chk("R9 done premarked", d, stw(0, 1, 1, 0, lmk, cnt));

    // mailbox single mark from clean
    clr_mark;
    wr(2'd0, 13'(1 << B));
    tx(1);
    chk("R10 snapshot clean", mbox_data, stw(0, 0, 0, 1, lmk, cnt));
    mbox_done = 1'b1; tick; mbox_done = 1'b0;
    rd(2'd0, d); chk("R9 done clean", d, stw(0, 1, 0, 0, lmk, cnt));
    chk("R9 req low", mbox_req, 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule